// File: doc/BRIEF.md
# Parallel Banked Byte Substitution Unit

This unit applies the AES byte substitution, forward or inverse, to every byte of a 128-bit state. A state enters over a valid/ready handshake together with a mode bit. The unit then runs it through a parameterised number of byte lanes, `LANES` bytes per clock. A lane resolves its byte in stages. Bits [7:6] pick one of four 64-entry banks. Bits [5:4] pick a row and bits [3:2] pick a column of that bank's 4x4 grid of four-entry tables. Bits [1:0] steer a 4-to-1 selector built from three 2-to-1 selectors. Every table entry is computed at elaboration from the finite-field inverse and the affine map. No table is stored as a literal.

`LANES` may be 4, 8 or 16, so a state takes `BEATS = 16/LANES` beats. In beat `b`, lane `i` handles state byte `b*LANES + i`. Byte `k` of the state sits at bits `[8k+7:8k]` on both input and output. The result waits in an output register until it is accepted downstream.

Back-pressure rules: `in_ready` is high only while the unit is idle, so a new state is refused from its acceptance until its result has been taken. `out_valid` stays high, and `out_state` stays unchanged, for as long as `out_ready` is low. The mode is sampled together with the state.

Top module: `sbox_stream_unit`

## Requirements
- R1: With the mode bit at 0 (forward), each output byte `k` (bits `[8k+7:8k]`) equals the AES S-box of input byte `k`, e.g. 00->63, 01->7c, 53->ed, ff->16.
- R2: With the mode bit at 1 (inverse), each output byte equals the inverse AES S-box of the input byte, e.g. 63->00, 00->52, ed->53, 16->ff.
- R3: All 256 byte values are substituted correctly in both modes through the bank / row / column / entry decode of bits [7:6], [5:4], [3:2], [1:0], with no position-dependent error across the 16 byte positions.
- R4: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R5: A state is accepted on a clock edge with `in_valid` and `in_ready` both high. From then until its result is taken, `in_ready` is 0, and any `in_valid` input is ignored and does not disturb the result.
- R6: `out_valid` rises on the edge `BEATS+1` cycles after the accepting edge, which is one cycle after the last beat is registered.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_state` is stable and `in_ready` stays 0. After the output handshake, the unit is idle with `in_ready` at 1 and `out_valid` at 0.
- R8: The mode bit is captured at the accepting edge, and a later change of `in_inverse` does not affect that state's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input state offered |
| in_ready | output | 1 | Unit idle and able to take a state |
| in_state | input | 128 | State to substitute, byte k at bits [8k+7:8k] |
| in_inverse | input | 1 | 0 forward substitution, 1 inverse substitution |
| out_valid | output | 1 | Substituted state available |
| out_ready | input | 1 | Downstream takes the result |
| out_state | output | 128 | Substituted state, byte k at bits [8k+7:8k] |

## Verification
The hardest case to reach from the ports is a change at the input while the lanes are still walking the beats of an earlier state. Here the upstream side offers a fresh state with the opposite mode, and the mode bit flips just after acceptance. The stimulus provokes it by raising `in_valid` with a second state right after the first is taken and holding it through the busy window. It also toggles `in_inverse` immediately after an accept. The bench then compares the first result, and afterwards the second one, against a model built from brute-force field inversion, and watches `in_ready` on every cycle of the window.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int BYTE_W  = 8;
  localparam int STATE_B = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN, ST_SEND} phase_t;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = 8'h00; x = a; y = b;
    for (int k = 0; k < 8; k++) begin
      if (y[0]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      y = {1'b0, y[7:1]};
    end
    return p;
  endfunction

  // a^254 is the multiplicative inverse; 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, base;
    logic [7:0] e;
    r = 8'h01; base = a; e = 8'd254;
    for (int k = 0; k < 8; k++) begin
      if (e[k]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
    logic [15:0] d;
    d = {b, b} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] fwd_sub(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sub(input logic [7:0] y);
    return gf_inv(rotl(y, 1) ^ rotl(y, 3) ^ rotl(y, 6) ^ 8'h05);
  endfunction
endpackage

// File: rtl/sbox_cell.sv
module sbox_cell #(
  parameter logic [7:0] BASE = 8'h00
) (
  input  logic [1:0] idx,
  input  logic       inverse,
  output logic [7:0] value
);
  logic [7:0] ent [4];

  for (genvar e = 0; e < 4; e++) begin : g_ent
    localparam logic [7:0] ADDR = BASE + 8'(e);
    localparam logic [7:0] F    = sbox_pkg::fwd_sub(ADDR);
    localparam logic [7:0] I    = sbox_pkg::inv_sub(ADDR);
    assign ent[e] = inverse ? I : F;
  end

  // 4-to-1 selection as three 2-to-1 stages
  logic [7:0] pick_lo, pick_hi;
  assign pick_lo = idx[0] ? ent[1] : ent[0];
  assign pick_hi = idx[0] ? ent[3] : ent[2];
  assign value   = idx[1] ? pick_hi : pick_lo;
endmodule

// File: rtl/sbox_bank.sv
module sbox_bank #(
  parameter logic [1:0] BANK = 2'd0
) (
  input  logic [1:0] row,
  input  logic [1:0] col,
  input  logic [1:0] entry,
  input  logic       inverse,
  input  logic       enable,
  output logic [7:0] value
);
  logic [3:0] row_hot, col_hot;
  logic [7:0] cell_val [16];
  logic [7:0] acc;

  assign row_hot = 4'b0001 << row;
  assign col_hot = 4'b0001 << col;

  for (genvar r = 0; r < 4; r++) begin : g_row
    for (genvar c = 0; c < 4; c++) begin : g_col
      localparam logic [7:0] CB = {BANK, 2'(r), 2'(c), 2'b00};
      logic [7:0] raw;
      sbox_cell #(.BASE(CB)) u_cell (.idx(entry), .inverse(inverse), .value(raw));
      assign cell_val[r*4+c] = raw & {8{row_hot[r] & col_hot[c]}};
    end
  end

  always_comb begin
    acc = 8'h00;
    for (int k = 0; k < 16; k++) acc = acc | cell_val[k];
  end

  assign value = acc & {8{enable}};
endmodule

// File: rtl/sbox_lane.sv
module sbox_lane (
  input  logic [7:0] din,
  input  logic       inverse,
  output logic [7:0] dout,
  output logic [3:0] bank_hot
);
  logic [7:0] bank_val [4];

  assign bank_hot = 4'b0001 << din[7:6];

  for (genvar g = 0; g < 4; g++) begin : g_bank
    sbox_bank #(.BANK(2'(g))) u_bank (
      .row(din[5:4]), .col(din[3:2]), .entry(din[1:0]),
      .inverse(inverse), .enable(bank_hot[g]), .value(bank_val[g]));
  end

  assign dout = bank_val[0] | bank_val[1] | bank_val[2] | bank_val[3];
endmodule

// File: rtl/sbox_stream_unit.sv
module sbox_stream_unit #(
  parameter int LANES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_state,
  input  logic         in_inverse,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_state
);
  import sbox_pkg::*;

  localparam int BEATS     = STATE_B / LANES;
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int LANE_BITS = LANES * BYTE_W;

  if ((LANES % 4) != 0 || (STATE_B % LANES) != 0) begin : g_bad_lanes
    $error("LANES must be 4, 8 or 16");
  end

  phase_t              phase;
  logic [BEAT_W-1:0]   beat_q;
  logic [127:0]        hold_q, res_q;
  logic                inv_q;
  logic [LANE_BITS-1:0] slice, sub;
  logic [3:0]          bank_hot [LANES];
  logic                last_beat;

  assign slice     = hold_q[beat_q*LANE_BITS +: LANE_BITS];
  assign last_beat = (beat_q == BEAT_W'(BEATS-1));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sbox_lane u_lane (
      .din(slice[i*8 +: 8]), .inverse(inv_q),
      .dout(sub[i*8 +: 8]), .bank_hot(bank_hot[i]));

    a_r3_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(bank_hot[i]));
    a_r1_zero_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_RUN && !inv_q && slice[i*8 +: 8] == 8'h00) |-> sub[i*8 +: 8] == 8'h63);
    a_r2_zero_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_RUN && inv_q && slice[i*8 +: 8] == 8'h63) |-> sub[i*8 +: 8] == 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      beat_q <= '0;
      hold_q <= '0;
      res_q  <= '0;
      inv_q  <= 1'b0;
    end else begin
      unique case (phase)
        ST_IDLE: if (in_valid) begin
          hold_q <= in_state;
          inv_q  <= in_inverse;
          beat_q <= '0;
          phase  <= ST_RUN;
        end
        ST_RUN: begin
          res_q[beat_q*LANE_BITS +: LANE_BITS] <= sub;
          if (last_beat) phase <= ST_FIN;
          else           beat_q <= beat_q + 1'b1;
        end
        ST_FIN:  phase <= ST_SEND;
        ST_SEND: if (out_ready) phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (phase == ST_IDLE);
  assign out_valid = (phase == ST_SEND);
  assign out_state = res_q;

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r6_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RUN && last_beat) |-> ##2 out_valid);
  a_r6_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(phase == ST_FIN));
  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state)));
  a_r7_no_ready_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/test_sbox_stream_unit.sv
module test_sbox_stream_unit;
  localparam int LANES = 4;
  localparam int BEATS = 16 / LANES;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_inverse = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [127:0] in_state = '0, out_state;

  int total = 0, failed = 0;
  logic [7:0] fwd_tab [256];
  logic [7:0] inv_tab [256];

  // {mode, input byte, expected byte}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7c}, {1'b0, 8'h53, 8'hed}, {1'b0, 8'hff, 8'h16},
    {1'b1, 8'h63, 8'h00}, {1'b1, 8'h00, 8'h52}, {1'b1, 8'hed, 8'h53}, {1'b1, 8'h16, 8'hff}};

  sbox_stream_unit #(.LANES(LANES)) i_sbox_stream_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_inverse(in_inverse), .out_valid(out_valid),
    .out_ready(out_ready), .out_state(out_state));

  always #2 clk = ~clk;

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int k = 7; k >= 0; k--) begin
      r = (r[7] ? ({r[6:0], 1'b0} ^ 8'h1b) : {r[6:0], 1'b0});
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] a);
    for (int b = 1; b < 256; b++) if (m_mul(a, 8'(b)) == 8'h01) return 8'(b);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_affine(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return o;
  endfunction

  function automatic logic [127:0] expect_state(input logic [127:0] st, input logic mode);
    logic [127:0] r;
    for (int k = 0; k < 16; k++)
      r[k*8 +: 8] = mode ? inv_tab[st[k*8 +: 8]] : fwd_tab[st[k*8 +: 8]];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic accept(input logic [127:0] st, input logic mode);
    @(negedge clk);
    in_state = st; in_inverse = mode; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(output int lat);
    lat = 1;
    while (!out_valid) begin @(negedge clk); lat++; end
  endtask

  task automatic drain;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int lat;
    logic [127:0] st, v0, exp;
    bit bad;
    for (int x = 0; x < 256; x++) begin
      fwd_tab[x] = m_affine(m_inv(8'(x)));
      inv_tab[fwd_tab[x]] = 8'(x);
    end

    // R4: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R4 during reset", {126'b0, out_valid, in_ready}, 128'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R4 after reset", {126'b0, out_valid, in_ready}, 128'h1);

    // R1/R2: known-value table, byte replicated across the state
    for (int v = 0; v < 8; v++) begin
      st = {16{VEC[v][15:8]}};
      accept(st, VEC[v][16]);
      wait_out(lat);
      exp = {16{VEC[v][7:0]}};
      chk(out_state == exp, VEC[v][16] ? "R2 known inverse value" : "R1 known forward value",
          out_state, exp);
      if (v == 0) chk(lat == BEATS + 2, "R6 latency", 128'(lat), 128'(BEATS + 2));
      drain;
    end

    // R3: full sweep, both modes, distinct bytes per position
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int k = 0; k < 16; k++) st[k*8 +: 8] = 8'(s*16 + k);
        accept(st, m[0]);
        wait_out(lat);
        exp = expect_state(st, m[0]);
        chk(out_state == exp, "R3 sweep", out_state, exp);
        chk(lat == BEATS + 2, "R6 latency sweep", 128'(lat), 128'(BEATS + 2));
        drain;
      end
    end

    // R5: second state offered while busy is ignored, then taken once idle
    st = 128'h0123456789abcdeffedcba9876543210;
    accept(st, 1'b0);
    in_state = 128'h00112233445566778899aabbccddeeff; in_inverse = 1'b1; in_valid = 1'b1;
    bad = 0;
    while (!out_valid) begin if (in_ready) bad = 1; @(negedge clk); end
    chk(!bad, "R5 in_ready low while busy", 128'(bad), 128'h0);
    exp = expect_state(st, 1'b0);
    chk(out_state == exp, "R5 busy input ignored", out_state, exp);
    drain;
    chk(in_ready, "R5 ready after handshake", 128'(in_ready), 128'h1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(lat);
    exp = expect_state(128'h00112233445566778899aabbccddeeff, 1'b1);
    chk(out_state == exp, "R5 held state taken when idle", out_state, exp);
    drain;

    // R7: back-pressure
    st = 128'hdeadbeef0badf00dcafebabe13579bdf;
    accept(st, 1'b0);
    wait_out(lat);
    v0 = out_state;
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (!out_valid || out_state != v0 || in_ready) bad = 1;
    end
    chk(!bad, "R7 output held under back-pressure", out_state, v0);
    exp = expect_state(st, 1'b0);
    chk(v0 == exp, "R7 held value", v0, exp);
    drain;
    chk(in_ready && !out_valid, "R7 idle after handshake", {126'b0, out_valid, in_ready}, 128'h1);

    // R8: mode flipped right after acceptance
    st = 128'h63636363000000005252525216161616;
    accept(st, 1'b1);
    in_inverse = 1'b0; in_state = '1;
    wait_out(lat);
    exp = expect_state(st, 1'b1);
    chk(out_state == exp, "R8 mode captured at accept", out_state, exp);
    drain;

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule